// File: doc/BRIEF.md
# Dual-Lane Half-Precision Operand Shaper and Result Writeback

This block sits on both sides of a two-lane FP16 arithmetic core. On the way in, it takes two 32-bit register sources and one short immediate and turns each into a pair of FP16 lanes. A register source can be split into its two halves, or one of its halves can be broadcast to both lanes. The whole word can also be read as an FP32 number, narrowed to FP16 and broadcast. Absolute value and negation then act on both lanes of that source. The immediate is built from two 9-bit fields, each with its own sign control. The operand side has no registers, so the lanes appear in the same cycle as the inputs.

On the way out, the block takes the core's two FP16 result lanes and the previous contents of the destination register. It forms the new 32-bit destination word in one of four ways:
- pack both lanes,
- widen lane 0 to FP32,
- insert lane 0 into the low half and keep the old high half,
- insert lane 1 into the high half and keep the old low half.

The word is registered and comes with a one-cycle valid strobe.

Top module: `hp_pair_stage`

## Requirements
- R1: With a source selector of 0, lane 0 carries source bits 15:0 and lane 1 carries bits 31:16.
- R2: With a source selector of 1, the 32-bit source is read as FP32 and converted to FP16 with round-to-nearest-even. The result is placed in both lanes.
- R3: In selector-1 conversion, any finite value of magnitude 65520 or more becomes a signed FP16 infinity (exponent 31, mantissa 0). An FP32 NaN with mantissa m becomes {sign, 5'h1f, 1, m[22:14]}.
- R4: A selector of 2 places source bits 15:0 in both lanes. A selector of 3 places bits 31:16 in both lanes.
- R5: The absolute-value control clears bit 15 of both lanes, and the negate control then inverts bit 15 of both lanes. With both controls set, the sign is 1.
- R6: Immediate lane 0 is {neg0, field0, 6'b0} and immediate lane 1 is {neg1, field1, 6'b0}. Each lane's negate control acts only on its own lane.
- R7: Writeback mode 0 produces {lane1, lane0}.
- R8: Writeback mode 1 produces the exact FP32 value of result lane 0, including FP16 subnormals. An FP16 infinity or NaN with mantissa m becomes {sign, 8'hff, m, 13'b0}.
- R9: Writeback mode 2 produces {old[31:16], lane0}, with the kept half bit-identical to the old destination.
- R10: Writeback mode 3 produces {lane1, old[15:0]}, with the kept half bit-identical to the old destination.
- R11: The destination word and its valid strobe change on the first clock edge after a writeback request. The strobe is high for exactly one cycle per request, and the word holds while no request is made. Reset clears the strobe and the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_word | input | 32 | Register source A |
| a_sel | input | 2 | Lane selector for A (0 split, 1 FP32, 2 low, 3 high) |
| a_abs | input | 1 | Absolute value on A |
| a_neg | input | 1 | Negate A |
| b_word | input | 32 | Register source B |
| b_sel | input | 2 | Lane selector for B |
| b_abs | input | 1 | Absolute value on B |
| b_neg | input | 1 | Negate B |
| imm_f0 | input | 9 | Immediate field for lane 0 |
| imm_f1 | input | 9 | Immediate field for lane 1 |
| imm_neg0 | input | 1 | Negate immediate lane 0 |
| imm_neg1 | input | 1 | Negate immediate lane 1 |
| a_lane0 | output | 16 | A, lane 0 |
| a_lane1 | output | 16 | A, lane 1 |
| b_lane0 | output | 16 | B, lane 0 |
| b_lane1 | output | 16 | B, lane 1 |
| imm_lane0 | output | 16 | Immediate, lane 0 |
| imm_lane1 | output | 16 | Immediate, lane 1 |
| wb_valid | input | 1 | Writeback request |
| wb_mode | input | 2 | Writeback mode (0 pack, 1 widen, 2 insert low, 3 insert high) |
| res_lane0 | input | 16 | Core result, lane 0 |
| res_lane1 | input | 16 | Core result, lane 1 |
| old_dst | input | 32 | Previous destination word |
| dst_valid | output | 1 | Destination word valid strobe |
| dst_word | output | 32 | Registered destination word |

## Verification
The only state in the block is the registered destination word and its strobe. A wrong value there shows at the ports one edge after the request:
- as a stale or corrupted kept half in the insert modes,
- as a strobe lasting more than one cycle,
- as a word that drifts while no request is made.

The bench samples the cycle after each request and the cycle after that, so a fault in that state is seen within two cycles. Faults in the operand side are combinational and show in the same cycle. Directed cases cover rounding ties, overflow to infinity, subnormals and NaN payloads.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int LANE_W    = 16;
    localparam int WORD_W    = 2 * LANE_W;
    localparam int IMM_W     = 9;
    localparam int IMM_SHIFT = LANE_W - 1 - IMM_W;
    localparam int NUM_SRC   = 2;

    typedef enum logic [1:0] {
        SEL_SPLIT = 2'd0,
        SEL_WIDE  = 2'd1,
        SEL_LOW   = 2'd2,
        SEL_HIGH  = 2'd3
    } lane_sel_e;

    typedef enum logic [1:0] {
        WB_PACK   = 2'd0,
        WB_WIDEN  = 2'd1,
        WB_INS_LO = 2'd2,
        WB_INS_HI = 2'd3
    } wb_mode_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
    } wb_state_t;

    // FP32 -> FP16, round to nearest even
    function automatic logic [15:0] f32_to_f16(input logic [31:0] w);
        logic        s;
        logic [7:0]  e;
        logic [22:0] m;
        logic [15:0] r;
        logic [63:0] ext;
        logic [23:0] q;
        logic        g;
        logic        st;
        logic        rnd;
        int          he;
        int          sh;
        s  = w[31];
        e  = w[30:23];
        m  = w[22:0];
        he = int'(e) - 112;
        if (e == 8'hff) begin
            r = (m != '0) ? {s, 5'h1f, 1'b1, m[22:14]} : {s, 15'h7c00};
        end else if (he >= 31) begin
            r = {s, 15'h7c00};
        end else if (he >= 1) begin
            g   = m[12];
            st  = |m[11:0];
            rnd = g & (st | m[13]);
            r   = {s, 15'({he[4:0], m[22:13]}) + 15'(rnd)};
        end else begin
            sh = 126 - int'(e);
            if (sh > 63) sh = 63;
            ext = {(e != 8'd0), m, 40'b0} >> sh;
            q   = ext[63:40];
            g   = ext[39];
            st  = |ext[38:0];
            rnd = g & (st | q[0]);
            r   = {s, 15'(q + 24'(rnd))};
        end
        return r;
    endfunction

    // FP16 -> FP32, exact
    function automatic logic [31:0] f16_to_f32(input logic [15:0] h);
        logic        s;
        logic [4:0]  e;
        logic [9:0]  m;
        logic [31:0] r;
        logic [22:0] frac;
        int          p;
        s = h[15];
        e = h[14:10];
        m = h[9:0];
        p = 0;
        if (e == 5'h1f) begin
            r = {s, 8'hff, m, 13'b0};
        end else if (e != 5'd0) begin
            r = {s, 8'(e) + 8'd112, m, 13'b0};
        end else if (m == '0) begin
            r = {s, 31'b0};
        end else begin
            for (int i = 0; i < 10; i++) begin
                if (m[i]) p = i;
            end
            frac = {13'b0, m} << (23 - p);
            r    = {s, 8'(p + 103), frac};
        end
        return r;
    endfunction
endpackage

// File: rtl/hp_src_unpack.sv
module hp_src_unpack
    import hp_pkg::*;
#(
    parameter int LW = LANE_W
) (
    input  logic [2*LW-1:0] word,
    input  logic [1:0]      sel,
    input  logic            abs_en,
    input  logic            neg_en,
    output logic [LW-1:0]   lane0,
    output logic [LW-1:0]   lane1
);
    localparam int WW = 2 * LW;
    logic [LW-1:0] raw0;
    logic [LW-1:0] raw1;
    logic [LW-1:0] narrowed;

    always_comb begin
        narrowed = LW'(f32_to_f16(32'(word)));
        unique case (lane_sel_e'(sel))
            SEL_SPLIT: begin raw0 = word[LW-1:0];  raw1 = word[WW-1:LW]; end
            SEL_WIDE:  begin raw0 = narrowed;      raw1 = narrowed;      end
            SEL_LOW:   begin raw0 = word[LW-1:0];  raw1 = word[LW-1:0];  end
            default:   begin raw0 = word[WW-1:LW]; raw1 = word[WW-1:LW]; end
        endcase
        lane0 = {(raw0[LW-1] & ~abs_en) ^ neg_en, raw0[LW-2:0]};
        lane1 = {(raw1[LW-1] & ~abs_en) ^ neg_en, raw1[LW-2:0]};
    end
endmodule

// File: rtl/hp_imm_unpack.sv
module hp_imm_unpack
    import hp_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int FW = IMM_W
) (
    input  logic [FW-1:0] f0,
    input  logic [FW-1:0] f1,
    input  logic          neg0,
    input  logic          neg1,
    output logic [LW-1:0] lane0,
    output logic [LW-1:0] lane1
);
    localparam int SH = LW - 1 - FW;

    always_comb begin
        lane0 = {neg0, f0, SH'(0)};
        lane1 = {neg1, f1, SH'(0)};
    end
endmodule

// File: rtl/hp_writeback.sv
module hp_writeback
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        mode,
    input  logic [LANE_W-1:0] res0,
    input  logic [LANE_W-1:0] res1,
    input  logic [WORD_W-1:0] old_word,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);
    wb_state_t st_d;
    wb_state_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = req;
        if (req) begin
            unique case (wb_mode_e'(mode))
                WB_PACK:   st_d.word = {res1, res0};
                WB_WIDEN:  st_d.word = WORD_W'(f16_to_f32(16'(res0)));
                WB_INS_LO: st_d.word = {old_word[WORD_W-1:LANE_W], res0};
                default:   st_d.word = {res1, old_word[LANE_W-1:0]};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;
endmodule

// File: rtl/hp_pair_stage.sv
module hp_pair_stage
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] a_word,
    input  logic [1:0]        a_sel,
    input  logic              a_abs,
    input  logic              a_neg,
    input  logic [WORD_W-1:0] b_word,
    input  logic [1:0]        b_sel,
    input  logic              b_abs,
    input  logic              b_neg,
    input  logic [IMM_W-1:0]  imm_f0,
    input  logic [IMM_W-1:0]  imm_f1,
    input  logic              imm_neg0,
    input  logic              imm_neg1,
    output logic [LANE_W-1:0] a_lane0,
    output logic [LANE_W-1:0] a_lane1,
    output logic [LANE_W-1:0] b_lane0,
    output logic [LANE_W-1:0] b_lane1,
    output logic [LANE_W-1:0] imm_lane0,
    output logic [LANE_W-1:0] imm_lane1,
    input  logic              wb_valid,
    input  logic [1:0]        wb_mode,
    input  logic [LANE_W-1:0] res_lane0,
    input  logic [LANE_W-1:0] res_lane1,
    input  logic [WORD_W-1:0] old_dst,
    output logic              dst_valid,
    output logic [WORD_W-1:0] dst_word
);
    logic [WORD_W-1:0] src_word [NUM_SRC];
    logic [1:0]        src_sel  [NUM_SRC];
    logic              src_abs  [NUM_SRC];
    logic              src_neg  [NUM_SRC];
    logic [LANE_W-1:0] src_l0   [NUM_SRC];
    logic [LANE_W-1:0] src_l1   [NUM_SRC];

    assign src_word[0] = a_word;  assign src_word[1] = b_word;
    assign src_sel[0]  = a_sel;   assign src_sel[1]  = b_sel;
    assign src_abs[0]  = a_abs;   assign src_abs[1]  = b_abs;
    assign src_neg[0]  = a_neg;   assign src_neg[1]  = b_neg;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        hp_src_unpack #(.LW(LANE_W)) u_unpack (
            .word   (src_word[gi]),
            .sel    (src_sel[gi]),
            .abs_en (src_abs[gi]),
            .neg_en (src_neg[gi]),
            .lane0  (src_l0[gi]),
            .lane1  (src_l1[gi])
        );
    end

    assign a_lane0 = src_l0[0];
    assign a_lane1 = src_l1[0];
    assign b_lane0 = src_l0[1];
    assign b_lane1 = src_l1[1];

    hp_imm_unpack #(.LW(LANE_W), .FW(IMM_W)) u_imm (
        .f0    (imm_f0),
        .f1    (imm_f1),
        .neg0  (imm_neg0),
        .neg1  (imm_neg1),
        .lane0 (imm_lane0),
        .lane1 (imm_lane1)
    );

    hp_writeback u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (wb_valid),
        .mode      (wb_mode),
        .res0      (res_lane0),
        .res1      (res_lane1),
        .old_word  (old_dst),
        .out_valid (dst_valid),
        .out_word  (dst_word)
    );
endmodule

// File: rtl/hp_stage_chk.sv
module hp_stage_chk
    import hp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        a_sel,
    input logic [LANE_W-1:0] a_lane0,
    input logic [LANE_W-1:0] a_lane1,
    input logic [1:0]        b_sel,
    input logic [LANE_W-1:0] b_lane0,
    input logic [LANE_W-1:0] b_lane1,
    input logic [LANE_W-1:0] imm_lane0,
    input logic [LANE_W-1:0] imm_lane1,
    input logic              wb_valid,
    input logic [1:0]        wb_mode,
    input logic [LANE_W-1:0] res_lane0,
    input logic [LANE_W-1:0] res_lane1,
    input logic [WORD_W-1:0] old_dst,
    input logic              dst_valid,
    input logic [WORD_W-1:0] dst_word
);
    always_comb begin
        if (rst_n) begin
            AST_A_BCAST_SAME: assert (a_sel == 2'd0 || a_lane0 == a_lane1) else $error("a lanes differ"); // R4
            AST_B_BCAST_SAME: assert (b_sel == 2'd0 || b_lane0 == b_lane1) else $error("b lanes differ"); // R2
            AST_IMM_LOW_ZERO: assert (imm_lane0[IMM_SHIFT-1:0] == '0 && imm_lane1[IMM_SHIFT-1:0] == '0) else $error("imm low bits"); // R6
        end
    end

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> dst_valid) else $error("strobe missing"); // R11
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |=> !dst_valid) else $error("strobe stuck"); // R11
    AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |=> $stable(dst_word)) else $error("word drifted"); // R11
    AST_PACK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_mode == 2'd0) |=> dst_word == {$past(res_lane1), $past(res_lane0)}) else $error("pack"); // R7
    AST_KEEP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_mode == 2'd2) |=> dst_word[WORD_W-1:LANE_W] == $past(old_dst[WORD_W-1:LANE_W])) else $error("keep hi"); // R9
    AST_KEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_mode == 2'd3) |=> dst_word[LANE_W-1:0] == $past(old_dst[LANE_W-1:0])) else $error("keep lo"); // R10
endmodule

bind hp_pair_stage hp_stage_chk u_chk (.*);

// File: tb/test_hp_pair_stage.sv
`timescale 1ns/1ps
module test_hp_pair_stage;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] a_word = '0, b_word = '0, old_dst = '0;
    logic [1:0]  a_sel = '0, b_sel = '0, wb_mode = '0;
    logic a_abs = 0, a_neg = 0, b_abs = 0, b_neg = 0, imm_neg0 = 0, imm_neg1 = 0, wb_valid = 0;
    logic [8:0]  imm_f0 = '0, imm_f1 = '0;
    logic [15:0] a_lane0, a_lane1, b_lane0, b_lane1, imm_lane0, imm_lane1;
    logic [15:0] res_lane0 = '0, res_lane1 = '0;
    logic        dst_valid;
    logic [31:0] dst_word;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    hp_pair_stage i_hp_pair_stage (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic real p2(input int n);
        real r = 1.0;
        if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
        else        for (int i = 0; i < -n; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic logic [15:0] ref_narrow(input logic [31:0] w);
        logic s = w[31];
        int e = int'(w[30:23]);
        int m = int'(w[22:0]);
        real v, q, r, fr;
        int ex;
        longint n;
        if (e == 255) return (m != 0) ? {s, 5'h1f, 1'b1, w[22:14]} : {s, 15'h7c00};
        v = (e == 0) ? real'(m) * p2(-149) : (real'(m) + p2(23)) * p2(e - 150);
        if (v >= 65520.0) return {s, 15'h7c00};
        if (v == 0.0) return {s, 15'h0};
        ex = -14;
        while (v >= p2(ex + 1)) ex++;
        q  = v / p2(ex - 10);
        r  = $floor(q);
        fr = q - r;
        n  = longint'(r);
        if (fr > 0.5 || (fr == 0.5 && n[0])) n++;
        if (ex == -14 && n < 1024) return {s, 15'(n)};
        return {s, 15'(longint'((ex + 15) * 1024) + n - 1024)};
    endfunction

    function automatic logic [31:0] ref_widen(input logic [15:0] h);
        logic s = h[15];
        int e = int'(h[14:10]);
        int m = int'(h[9:0]);
        real v;
        int ex;
        if (e == 31) return {s, 8'hff, h[9:0], 13'b0};
        if (e == 0 && m == 0) return {s, 31'b0};
        v = (e == 0) ? real'(m) * p2(-24) : real'(1024 + m) * p2(e - 25);
        ex = -30;
        while (v >= p2(ex + 1)) ex++;
        return {s, 8'(ex + 127), 23'(longint'((v / p2(ex) - 1.0) * p2(23)))};
    endfunction

    function automatic logic [15:0] fix_sign(input logic [15:0] x, input logic ab, input logic ng);
        return {(ab ? 1'b0 : x[15]) ^ ng, x[14:0]};
    endfunction

    task automatic src_case(input logic [31:0] w, input logic [1:0] sel, input logic ab, input logic ng, input string tag);
        logic [15:0] e0, e1;
        @(negedge clk);
        a_word = w; a_sel = sel; a_abs = ab; a_neg = ng;
        b_word = ~w; b_sel = sel; b_abs = ng; b_neg = ab;
        case (sel)
            2'd0: begin e0 = w[15:0]; e1 = w[31:16]; end
            2'd1: begin e0 = ref_narrow(w); e1 = e0; end
            2'd2: begin e0 = w[15:0]; e1 = w[15:0]; end
            default: begin e0 = w[31:16]; e1 = w[31:16]; end
        endcase
        #1;
        chk({tag, " lane0"}, 32'(a_lane0), 32'(fix_sign(e0, ab, ng)));
        chk({tag, " lane1"}, 32'(a_lane1), 32'(fix_sign(e1, ab, ng)));
        case (sel)
            2'd0: begin e0 = ~w[15:0]; e1 = ~w[31:16]; end
            2'd1: begin e0 = ref_narrow(~w); e1 = e0; end
            2'd2: begin e0 = ~w[15:0]; e1 = ~w[15:0]; end
            default: begin e0 = ~w[31:16]; e1 = ~w[31:16]; end
        endcase
        chk({tag, " b lane0"}, 32'(b_lane0), 32'(fix_sign(e0, ng, ab)));
        chk({tag, " b lane1"}, 32'(b_lane1), 32'(fix_sign(e1, ng, ab)));
    endtask

    task automatic imm_case(input logic [8:0] f0, input logic [8:0] f1, input logic n0, input logic n1);
        @(negedge clk);
        imm_f0 = f0; imm_f1 = f1; imm_neg0 = n0; imm_neg1 = n1;
        #1;
        chk("R6 imm lane0", 32'(imm_lane0), 32'({n0, f0, 6'b0}));
        chk("R6 imm lane1", 32'(imm_lane1), 32'({n1, f1, 6'b0}));
    endtask

    task automatic wb_case(input logic [1:0] md, input logic [15:0] r0, input logic [15:0] r1, input logic [31:0] od);
        logic [31:0] exp;
        string tag;
        case (md)
            2'd0: begin exp = {r1, r0}; tag = "R7 pack"; end
            2'd1: begin exp = ref_widen(r0); tag = "R8 widen"; end
            2'd2: begin exp = {od[31:16], r0}; tag = "R9 insert low"; end
            default: begin exp = {r1, od[15:0]}; tag = "R10 insert high"; end
        endcase
        @(negedge clk);
        wb_valid = 1'b1; wb_mode = md; res_lane0 = r0; res_lane1 = r1; old_dst = od;
        @(negedge clk);
        wb_valid = 1'b0; res_lane0 = ~r0; res_lane1 = ~r1; old_dst = ~od;
        chk("R11 strobe set", 32'(dst_valid), 32'd1);
        chk(tag, dst_word, exp);
        @(negedge clk);
        chk("R11 strobe one cycle", 32'(dst_valid), 32'd0);
        chk("R11 word holds", dst_word, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        #7;
        chk("R11 reset strobe", 32'(dst_valid), 32'd0);
        chk("R11 reset word", dst_word, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed operand cases
        src_case(32'hc123_3c00, 2'd0, 0, 0, "R1 split");
        src_case(32'hc123_3c00, 2'd2, 0, 0, "R4 low bcast");
        src_case(32'hc123_3c00, 2'd3, 0, 0, "R4 high bcast");
        src_case(32'hc123_3c00, 2'd3, 1, 0, "R5 abs");
        src_case(32'h4123_bc00, 2'd0, 0, 1, "R5 neg");
        src_case(32'hc123_bc00, 2'd0, 1, 1, "R5 abs then neg");
        src_case(32'h3f80_0000, 2'd1, 0, 0, "R2 one");
        src_case(32'h3f80_1000, 2'd1, 0, 0, "R2 tie to even down");
        src_case(32'h3f80_3000, 2'd1, 0, 0, "R2 tie to even up");
        src_case(32'h477f_e000, 2'd1, 0, 0, "R2 max finite");
        src_case(32'h3380_0000, 2'd1, 0, 0, "R2 min subnormal");
        src_case(32'h3300_0000, 2'd1, 0, 0, "R2 half of min subnormal");
        src_case(32'h3880_0000, 2'd1, 0, 0, "R2 min normal");
        src_case(32'h477f_f000, 2'd1, 0, 0, "R3 overflow tie");
        src_case(32'hc780_0000, 2'd1, 0, 0, "R3 negative overflow");
        src_case(32'h7fc0_0001, 2'd1, 0, 0, "R3 nan");
        src_case(32'hff80_0000, 2'd1, 0, 0, "R3 infinity");

        imm_case(9'h1ff, 9'h000, 0, 0);
        imm_case(9'h0f0, 9'h0f0, 1, 0);
        imm_case(9'h0f0, 9'h0f0, 0, 1);

        wb_case(2'd0, 16'h3c00, 16'hc000, 32'hdead_beef);
        wb_case(2'd1, 16'h3c00, 16'h1111, 32'h0);
        wb_case(2'd1, 16'h0001, 16'h0, 32'h0);
        wb_case(2'd1, 16'h83ff, 16'h0, 32'h0);
        wb_case(2'd1, 16'h7d01, 16'h0, 32'h0);
        wb_case(2'd1, 16'hfc00, 16'h0, 32'h0);
        wb_case(2'd2, 16'h1234, 16'h5678, 32'hcafe_f00d);
        wb_case(2'd3, 16'h1234, 16'h5678, 32'hcafe_f00d);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w = $urandom;
            logic [1:0] sel = 2'($urandom);
            if ((i % 2) == 0) begin
                sel = 2'd1;
                w[30:23] = 8'(95 + ($urandom % 60));
            end
            src_case(w, sel, 1'($urandom), 1'($urandom), "R1 R2 R4 R5 random");
        end
        for (int i = 0; i < 100; i++)
            imm_case(9'($urandom), 9'($urandom), 1'($urandom), 1'($urandom));
        for (int i = 0; i < 300; i++)
            wb_case(2'($urandom), 16'($urandom), 16'($urandom), $urandom);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule